// File: doc/BRIEF.md
# Asynchronous Memory Bank Register File and Decoder

This block holds the control registers of an external asynchronous-memory controller. It also turns a memory-side address into bank chip-selects. A narrow register port gives access to three registers:

- one 16-bit global control word;
- two 32-bit bank timing words.

Each access names a byte offset, a transfer size in bytes, and a read or write strobe. The port returns read data and an error flag with a two-bit error code one clock later.

A three-bit count field in the global control word sets how many of four contiguous external banks respond, starting from bank 0. The decoder compares the memory-side address with the region base and the bank size. It raises a one-hot chip-select for an enabled bank and a miss flag otherwise. Timing generation on the external pins, arbitration and flash modes belong to other blocks.

Top module: `xmem_bank_ctl`

## Requirements
- R1: After reset, the global control word reads 0x00F2 and both timing words read 0xFFC2FFC2. The count field starts at 1, so only bank 0 responds.
- R2: An access of any size other than 2 or 4 bytes is an error with code 1 (bad size). This holds even at an undefined offset, because the size check wins over the offset check.
- R3: The global control word (offset 0x0) accepts only 2-byte accesses. A 4-byte read or write to it is an error with code 1, and the word keeps its value.
- R4: Any offset other than 0x0, 0x4 (timing word 0) and 0x8 (timing word 1) gives an error with code 2 (bad offset). A write there changes no register.
- R5: For every access, response data, regErr and regErrCode appear on the clock after the strobe. An erroring access returns data 0, regErr high and a nonzero code (1 = size, 2 = offset). A good access returns code 0.
- R6: A 4-byte write to a timing word stores all 32 bits, and a 4-byte read returns all 32 bits.
- R7: A 2-byte access to a timing word touches only bits [15:0]. A read returns those bits zero-extended. A write leaves bits [31:16] unchanged.
- R8: The number of enabled banks is global bits [3:1], clamped to 4. Bank i responds only when i is less than that count.
- R9: An address in enabled bank i drives bankSel with only bit i set and bankMiss low. Bank i spans base + i·2^BANK_LOG2 up to the start of the next bank.
- R10: An address below the base, at or above base + 4·2^BANK_LOG2, or inside a disabled bank drives bankSel to 0 and bankMiss high.
- R11: A write to the global control word changes bank decoding from the clock edge that accepts the write onward.
- R12: In a cycle after a clock with no strobe, regRdata is 0, regErr is low and regErrCode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | REG_AW | Register byte offset |
| regWdata | input | 32 | Write data, low bits used for 2-byte writes |
| regSize | input | 3 | Access size in bytes |
| regRd | input | 1 | Read strobe |
| regWr | input | 1 | Write strobe (wins if both are high) |
| regRdata | output | 32 | Read data, one clock after the strobe |
| regErr | output | 1 | Error flag, one clock after the strobe |
| regErrCode | output | 2 | 0 none, 1 bad size, 2 bad offset |
| memAddr | input | MEM_AW | Memory-side byte address |
| bankSel | output | NUM_BANKS | One-hot bank chip-select |
| bankMiss | output | 1 | Address hits no enabled bank |

## Verification
Register responses are registered once, so each one is due at the first rising edge after the strobe cycle. The driver applies a strobe at a falling edge and queues the expected data and code. The monitor pops and compares that entry one time unit after the next rising edge.

Bank decode is combinational from memAddr and the stored count field. Decode checks therefore apply an address at a falling edge and sample shortly after. A decode check placed right after a global-control write sees the new count, because the write edge lies between the two.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

  localparam int NUM_TREG = 2;
  localparam int TIDX_W   = (NUM_TREG > 1) ? $clog2(NUM_TREG) : 1;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_SIZE   = 2'd1,
    ERR_OFFSET = 2'd2
  } errCode_e;

  typedef struct packed {
    logic                wrGlb;
    logic [NUM_TREG-1:0] wrLo;
    logic [NUM_TREG-1:0] wrHi;
    logic                rdEn;
    logic                rdGlb;
    logic [TIDX_W-1:0]   rdIdx;
    logic                rdWide;
    errCode_e            err;
  } ctlStb_t;

endpackage

// File: rtl/xmem_ctl.sv
module xmem_ctl
  import xmem_pkg::*;
#(
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [2:0]        regSize,
  input  logic              regRd,
  input  logic              regWr,
  output ctlStb_t           stb
);

  logic              access;
  logic              sizeOk;
  logic              isGlb;
  logic              tHit;
  logic [TIDX_W-1:0] tIdx;

  always_comb begin
    access = regRd | regWr;
    sizeOk = (regSize == 3'd2) || (regSize == 3'd4);
    isGlb  = (regAddr == '0);
    tHit   = 1'b0;
    tIdx   = '0;
    for (int k = 0; k < NUM_TREG; k++) begin
      if (regAddr == REG_AW'(4 * (k + 1))) begin
        tHit = 1'b1;
        tIdx = TIDX_W'(k);
      end
    end
  end

  always_comb begin
    stb = '0;
    if (!access)                     stb.err = ERR_NONE;
    else if (!sizeOk)                stb.err = ERR_SIZE;
    else if (isGlb && regSize != 3'd2) stb.err = ERR_SIZE;
    else if (!(isGlb || tHit))       stb.err = ERR_OFFSET;
    else                             stb.err = ERR_NONE;

    if (access && stb.err == ERR_NONE) begin
      if (regWr) begin
        stb.wrGlb = isGlb;
        for (int k = 0; k < NUM_TREG; k++) begin
          if (tHit && tIdx == TIDX_W'(k)) begin
            stb.wrLo[k] = 1'b1;
            stb.wrHi[k] = (regSize == 3'd4);
          end
        end
      end else begin
        stb.rdEn   = 1'b1;
        stb.rdGlb  = isGlb;
        stb.rdIdx  = tIdx;
        stb.rdWide = (regSize == 3'd4);
      end
    end
  end

  // R2: a size other than 2 or 4 must never pass as a good access
  a_r2_size_gate: assert property (@(posedge clk) disable iff (!rstN)
    (access && regSize != 3'd2 && regSize != 3'd4) |-> (stb.err == ERR_SIZE));

  // R3: no write strobe reaches the global word on a 4-byte access
  a_r3_glb_size: assert property (@(posedge clk) disable iff (!rstN)
    (regSize == 3'd4) |-> !stb.wrGlb);

endmodule

// File: rtl/xmem_dp.sv
module xmem_dp
  import xmem_pkg::*;
#(
  parameter logic [15:0] GLB_RESET  = 16'h00F2,
  parameter logic [31:0] TREG_RESET = 32'hFFC2FFC2,
  parameter int          EN_LSB     = 1,
  parameter int          EN_W       = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStb_t         stb,
  input  logic [31:0]     regWdata,
  output logic [31:0]     regRdata,
  output errCode_e        errCode,
  output logic [EN_W-1:0] enField
);

  logic [15:0] glbReg;
  logic [31:0] tReg [NUM_TREG];
  logic [31:0] rdVal;

  always_ff @(posedge clk) begin
    if (!rstN) glbReg <= GLB_RESET;
    else if (stb.wrGlb) glbReg <= regWdata[15:0];
  end

  for (genvar k = 0; k < NUM_TREG; k++) begin : gTreg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        tReg[k] <= TREG_RESET;
      end else begin
        if (stb.wrLo[k]) tReg[k][15:0]  <= regWdata[15:0];
        if (stb.wrHi[k]) tReg[k][31:16] <= regWdata[31:16];
      end
    end

    // R7: a half write keeps the upper half of the timing word
    a_r7_hi_keep: assert property (@(posedge clk) disable iff (!rstN)
      (stb.wrLo[k] && !stb.wrHi[k]) |=> (tReg[k][31:16] == $past(tReg[k][31:16])));
  end

  always_comb begin
    if (stb.rdGlb)       rdVal = {16'h0000, glbReg};
    else if (stb.rdWide) rdVal = tReg[stb.rdIdx];
    else                 rdVal = {16'h0000, tReg[stb.rdIdx][15:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdata <= '0;
      errCode  <= ERR_NONE;
    end else begin
      regRdata <= stb.rdEn ? rdVal : '0;
      errCode  <= stb.err;
    end
  end

  assign enField = glbReg[EN_LSB +: EN_W];

  // R3: an erroring access leaves the global word as it was
  a_r3_glb_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stb.err != ERR_NONE) |=> (glbReg == $past(glbReg)));

  // R5: error responses carry zero data
  a_r5_err_zero: assert property (@(posedge clk) disable iff (!rstN)
    (errCode != ERR_NONE) |-> (regRdata == '0));

endmodule

// File: rtl/xmem_bank_dec.sv
module xmem_bank_dec #(
  parameter int              MEM_AW    = 32,
  parameter logic [MEM_AW-1:0] BASE_ADDR = 32'h2000_0000,
  parameter int              BANK_LOG2 = 20,
  parameter int              NUM_BANKS = 4,
  parameter int              EN_W      = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [MEM_AW-1:0]    memAddr,
  input  logic [EN_W-1:0]      enField,
  output logic [NUM_BANKS-1:0] bankSel,
  output logic                 bankMiss
);

  localparam int SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam logic [MEM_AW-1:0] REGION_BYTES = MEM_AW'(NUM_BANKS) << BANK_LOG2;

  logic [MEM_AW-1:0] rel;
  logic              inRegion;
  logic [SEL_W-1:0]  idx;
  logic [EN_W-1:0]   enCount;

  assign rel      = memAddr - BASE_ADDR;
  assign inRegion = (memAddr >= BASE_ADDR) && (rel < REGION_BYTES);
  assign idx      = rel[BANK_LOG2 +: SEL_W];
  assign enCount  = (enField > EN_W'(NUM_BANKS)) ? EN_W'(NUM_BANKS) : enField;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : gBank
    assign bankSel[i] = inRegion && (idx == SEL_W'(i)) && (EN_W'(i) < enCount);

    // R8: a bank answers only while the count field covers it
    a_r8_bank_enabled: assert property (@(posedge clk) disable iff (!rstN)
      bankSel[i] |-> (enField > EN_W'(i)));
  end

  assign bankMiss = ~|bankSel;

  // R9: at most one chip-select at a time
  a_r9_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bankSel));

  // R10: addresses outside the region always miss
  a_r10_outside_miss: assert property (@(posedge clk) disable iff (!rstN)
    !inRegion |-> (bankMiss && bankSel == '0));

endmodule

// File: rtl/xmem_bank_ctl.sv
module xmem_bank_ctl
  import xmem_pkg::*;
#(
  parameter int                REG_AW    = 4,
  parameter int                MEM_AW    = 32,
  parameter logic [MEM_AW-1:0] BASE_ADDR = 32'h2000_0000,
  parameter int                BANK_LOG2 = 20,
  parameter int                NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [REG_AW-1:0]    regAddr,
  input  logic [31:0]          regWdata,
  input  logic [2:0]           regSize,
  input  logic                 regRd,
  input  logic                 regWr,
  output logic [31:0]          regRdata,
  output logic                 regErr,
  output logic [1:0]           regErrCode,
  input  logic [MEM_AW-1:0]    memAddr,
  output logic [NUM_BANKS-1:0] bankSel,
  output logic                 bankMiss
);

  localparam int EN_LSB = 1;
  localparam int EN_W   = 3;

  ctlStb_t         stb;
  errCode_e        errCode;
  logic [EN_W-1:0] enField;

  xmem_ctl #(.REG_AW(REG_AW)) uCtl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regSize(regSize),
    .regRd(regRd), .regWr(regWr), .stb(stb)
  );

  xmem_dp #(.EN_LSB(EN_LSB), .EN_W(EN_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .regWdata(regWdata),
    .regRdata(regRdata), .errCode(errCode), .enField(enField)
  );

  xmem_bank_dec #(
    .MEM_AW(MEM_AW), .BASE_ADDR(BASE_ADDR), .BANK_LOG2(BANK_LOG2),
    .NUM_BANKS(NUM_BANKS), .EN_W(EN_W)
  ) uDec (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .enField(enField),
    .bankSel(bankSel), .bankMiss(bankMiss)
  );

  assign regErrCode = errCode;
  assign regErr     = (errCode != ERR_NONE);

  // R5: a response flag only follows a strobe
  a_r5_err_follows_strobe: assert property (@(posedge clk) disable iff (!rstN)
    regErr |-> $past(regRd || regWr));

endmodule

// File: tb/sim_xmem_bank_ctl.sv
module sim_xmem_bank_ctl;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h2000_0000;
  localparam logic [31:0] BANK = 32'h0010_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [2:0]  regSize = '0;
  logic        regRd = 1'b0;
  logic        regWr = 1'b0;
  logic [31:0] regRdata;
  logic        regErr;
  logic [1:0]  regErrCode;
  logic [31:0] memAddr = '0;
  logic [3:0]  bankSel;
  logic        bankMiss;

  int errors = 0;
  int checks = 0;

  typedef struct {
    logic [31:0] rdata;
    logic [1:0]  code;
    string       tag;
  } expItem_t;

  expItem_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  xmem_bank_ctl u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata),
    .regSize(regSize), .regRd(regRd), .regWr(regWr), .regRdata(regRdata),
    .regErr(regErr), .regErrCode(regErrCode), .memAddr(memAddr),
    .bankSel(bankSel), .bankMiss(bankMiss)
  );

  task automatic access(input logic wr, input logic [3:0] a, input logic [2:0] sz,
                        input logic [31:0] wd, input logic [31:0] expRd,
                        input logic [1:0] expCode, input string tag);
    expItem_t it;
    @(negedge clk);
    regWr = wr; regRd = ~wr; regAddr = a; regSize = sz; regWdata = wd;
    it.rdata = expRd; it.code = expCode; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic checkDec(input logic [31:0] a, input logic [3:0] expSel, input string tag);
    @(negedge clk);
    regRd = 1'b0; regWr = 1'b0; memAddr = a;
    #1;
    checks++;
    if (bankSel !== expSel || bankMiss !== (expSel == 4'b0)) begin
      errors++;
      $display("FAIL %s: addr=%h sel=%b miss=%b expected sel=%b miss=%b",
               tag, a, bankSel, bankMiss, expSel, (expSel == 4'b0));
    end
  endtask

  // monitor: one response per strobe, due one edge later
  always @(posedge clk) begin
    #1;
    if (sbq.size() > 0) begin
      expItem_t it;
      it = sbq.pop_front();
      checks++;
      if (regRdata !== it.rdata || regErrCode !== it.code || regErr !== (it.code != 2'd0)) begin
        errors++;
        $display("FAIL %s: rdata=%h err=%b code=%0d expected rdata=%h err=%b code=%0d",
                 it.tag, regRdata, regErr, regErrCode, it.rdata, (it.code != 2'd0), it.code);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset values and initial decode
    access(0, 4'h0, 3'd2, 0, 32'h0000_00F2, 0, "R1 glb reset");
    access(0, 4'h4, 3'd4, 0, 32'hFFC2_FFC2, 0, "R1 treg0 reset");
    access(0, 4'h8, 3'd4, 0, 32'hFFC2_FFC2, 0, "R1 treg1 reset");
    checkDec(BASE + 32'h10, 4'b0001, "R1 bank0 enabled after reset");
    checkDec(BASE + BANK, 4'b0000, "R1 bank1 disabled after reset");

    // R12 idle response
    @(negedge clk); regRd = 0; regWr = 0;
    @(posedge clk); #2;
    checks++;
    if (regRdata !== 0 || regErr !== 0 || regErrCode !== 0) begin
      errors++;
      $display("FAIL R12 idle: rdata=%h err=%b code=%0d expected 0/0/0", regRdata, regErr, regErrCode);
    end

    // R6 full-width timing word
    access(1, 4'h4, 3'd4, 32'h1234_5678, 0, 0, "R6 write treg0");
    access(0, 4'h4, 3'd4, 0, 32'h1234_5678, 0, "R6 read treg0");
    // R7 half access
    access(1, 4'h4, 3'd2, 32'hFFFF_ABCD, 0, 0, "R7 half write treg0");
    access(0, 4'h4, 3'd4, 0, 32'h1234_ABCD, 0, "R7 upper half kept");
    access(0, 4'h4, 3'd2, 0, 32'h0000_ABCD, 0, "R7 half read treg0");
    access(0, 4'h8, 3'd2, 0, 32'h0000_FFC2, 0, "R7 half read treg1");

    // R3 global word size rule
    access(1, 4'h0, 3'd4, 32'h0000_0008, 0, 1, "R3 wide write glb");
    access(0, 4'h0, 3'd2, 0, 32'h0000_00F2, 0, "R3 glb unchanged");
    access(0, 4'h0, 3'd4, 0, 0, 1, "R3 wide read glb");

    // R2 size errors win over offset errors
    access(1, 4'hC, 3'd1, 32'hDEAD_BEEF, 0, 1, "R2 byte write unmapped");
    access(0, 4'h0, 3'd3, 0, 0, 1, "R2 size3 read");
    access(0, 4'h8, 3'd0, 0, 0, 1, "R2 size0 read");

    // R4 unmapped offsets
    access(1, 4'hC, 3'd4, 32'h0000_0000, 0, 2, "R4 write 0xC");
    access(1, 4'h2, 3'd2, 32'h0000_000E, 0, 2, "R4 write 0x2");
    access(0, 4'h6, 3'd2, 0, 0, 2, "R4 read 0x6");
    access(0, 4'h0, 3'd2, 0, 32'h0000_00F2, 0, "R4 glb intact");
    access(0, 4'h4, 3'd4, 0, 32'h1234_ABCD, 0, "R4 treg0 intact");
    access(0, 4'h8, 3'd4, 0, 32'hFFC2_FFC2, 0, "R4 treg1 intact");

    // R8 / R11 count field and immediate re-decode
    access(1, 4'h0, 3'd2, 32'h0000_0006, 0, 0, "R11 glb count 3");
    checkDec(BASE + 2*BANK + 32'h40, 4'b0100, "R11 bank2 enabled");
    checkDec(BASE + 3*BANK, 4'b0000, "R8 bank3 disabled at count 3");
    checkDec(BASE + BANK + 32'hF_FFFF, 4'b0010, "R9 last byte of bank1");
    access(1, 4'h0, 3'd2, 32'h0000_000E, 0, 0, "R8 glb count 7");
    checkDec(BASE + 3*BANK + 32'h8, 4'b1000, "R8 clamp to 4 banks");
    checkDec(BASE + 4*BANK, 4'b0000, "R10 above region");
    checkDec(BASE - 32'h1, 4'b0000, "R10 below region");
    checkDec(BASE, 4'b0001, "R9 first byte of bank0");
    access(1, 4'h0, 3'd2, 32'h0000_0000, 0, 0, "R11 glb count 0");
    checkDec(BASE, 4'b0000, "R11 bank0 disabled at count 0");
    access(0, 4'h0, 3'd2, 0, 32'h0000_0000, 0, "R11 glb readback");

    @(negedge clk); regRd = 0; regWr = 0;
    repeat (3) @(posedge clk);
    #2;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule